// File: doc/BRIEF.md
# Sequential Single-Precision Adder/Subtractor

This unit adds or subtracts two 32-bit binary floating-point values in the common single-precision layout. It accepts a pair of operands and an operation select when a load strobe is seen while the unit is idle. It then works on that single operation for a fixed number of cycles and presents a 32-bit result together with a three-bit exception code. A busy flag is high while the work is in progress. A caller waits for busy to drop, reads the result, and may load the next pair in that same idle cycle.

Internally a small sequencer steps the datapath through five phases: unpacking, alignment, magnitude add or subtract, normalisation, and rounding. It then holds the finished word until the fixed latency has run out. Zero, subnormal and normal operands are all accepted. Infinities and NaNs are handled, results that overflow saturate to infinity, and every finite result is rounded to nearest with ties to even.

Top module: `spAddSub`

## Requirements
- R1: Each operand carries the sign in bit 31, the biased exponent in bits 30:23 and the fraction in bits 22:0. `doAdd`=1 computes opLeft+opRight, and `doAdd`=0 computes opLeft-opRight.
- R2: When `loadStrobe` is high at a rising edge while `busy` is low, the operands and select are taken at that edge and `busy` is high after it. Without the strobe, `busy` stays low.
- R3: `busy` stays high for exactly 12 clock cycles after the capture edge. `result` and `excStatus` change only at the edge where `busy` falls, and they hold their values while idle.
- R4: A `loadStrobe` pulse while `busy` is high is ignored: the running operation finishes on time with its original operands.
- R5: Finite results are rounded to nearest, with an exact halfway case going to the value whose fraction LSB is 0.
- R6: Subnormal operands are valid inputs. A nonzero result with exponent field 0 is delivered as a subnormal with `excStatus`=3'b001.
- R7: A finite result too large to represent becomes an infinity of the result's sign (exponent all ones, fraction 0), with `excStatus`=3'b010.
- R8: An infinite operand gives an infinity of that operand's effective sign, with `excStatus`=3'b010, unless R9 applies.
- R9: A NaN operand, or infinities of opposite effective sign, give 32'h7FC00000 with `excStatus`=3'b100.
- R10: An exact zero result is +0, except when both effective operands are -0, in which case it is -0. In both cases `excStatus`=3'b000.
- R11: After reset `busy` is 0, `result` is 0 and `excStatus` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low reset |
| opLeft | input | 32 | First operand |
| opRight | input | 32 | Second operand |
| doAdd | input | 1 | 1 selects add, 0 selects subtract |
| loadStrobe | input | 1 | Operand load request |
| result | output | 32 | Sum or difference, valid while busy is low |
| excStatus | output | 3 | Bit 2 NaN, bit 1 infinity, bit 0 subnormal result |
| busy | output | 1 | High while an operation is in progress |

## Verification
A sequencer step that is off by one shows up at the ports within a single operation. The bench sees it as a busy window that is not exactly 12 cycles, or as a result that reflects a stage which was skipped or run twice. Bad alignment or a bad sticky bit in the datapath appears as a one-ULP miscompare on halfway and near-cancellation cases, at the moment busy falls. A capture register that is wrongly overwritten while busy shows up as the wrong result of that same operation.

// File: rtl/spAddPkg.sv
package spAddPkg;

  // One-cycle strobes from the sequencer to the datapath.
  typedef struct packed {
    logic capture;
    logic unpack;
    logic align;
    logic addStep;
    logic norm;
    logic round;
    logic finish;
  } stepStrb_t;

endpackage

// File: rtl/spAddCtrl.sv
module spAddCtrl
  import spAddPkg::*;
#(
  parameter int LATENCY = 12
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadStrobe,
  output logic      busy,
  output stepStrb_t strb
);

  localparam int CNT_W = $clog2(LATENCY);

  logic             busyQ;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strb         = '0;
    strb.capture = loadStrobe && !busyQ;
    strb.unpack  = busyQ && (stepCnt == CNT_W'(0));
    strb.align   = busyQ && (stepCnt == CNT_W'(1));
    strb.addStep = busyQ && (stepCnt == CNT_W'(2));
    strb.norm    = busyQ && (stepCnt == CNT_W'(3));
    strb.round   = busyQ && (stepCnt == CNT_W'(4));
    strb.finish  = busyQ && (stepCnt == CNT_W'(LATENCY - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      stepCnt <= '0;
    end else if (strb.capture) begin
      busyQ   <= 1'b1;
      stepCnt <= '0;
    end else if (busyQ) begin
      if (strb.finish) busyQ <= 1'b0;
      stepCnt <= stepCnt + CNT_W'(1);
    end
  end

  assign busy = busyQ;

  // R2: busy only rises after a requested load
  a_r2_rise_on_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(loadStrobe));

  // R3: busy only falls once the full step count has elapsed
  a_r3_fall_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> ($past(stepCnt) == CNT_W'(LATENCY - 1)));

endmodule

// File: rtl/spAddPath.sv
module spAddPath
  import spAddPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [EXP_W+FRAC_W:0]   opLeft,
  input  logic [EXP_W+FRAC_W:0]   opRight,
  input  logic                    doAdd,
  input  stepStrb_t               strb,
  output logic [EXP_W+FRAC_W:0]   result,
  output logic [2:0]              excStatus
);

  localparam int W      = 1 + EXP_W + FRAC_W;
  localparam int MW     = FRAC_W + 1;
  localparam int XW     = MW + 3;
  localparam int EI_W   = EXP_W + 2;
  localparam int LZ_W   = $clog2(XW + 1);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [W-1:0] NAN_WORD = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  // capture
  logic [W-1:0] opAQ, opBQ;
  logic         subQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opAQ <= '0; opBQ <= '0; subQ <= 1'b0;
    end else if (strb.capture) begin
      opAQ <= opLeft; opBQ <= opRight; subQ <= !doAdd;
    end
  end

  // unpack: classify, make effective sign, order by magnitude
  logic              sgnA, sgnB;
  logic [EXP_W-1:0]  expA, expB, effA, effB;
  logic [FRAC_W-1:0] fracA, fracB;
  logic [MW-1:0]     mantA, mantB;
  logic              nanA, nanB, infA, infB, aBig;

  always_comb begin
    sgnA  = opAQ[W-1];
    sgnB  = opBQ[W-1] ^ subQ;
    expA  = opAQ[W-2:FRAC_W];
    expB  = opBQ[W-2:FRAC_W];
    fracA = opAQ[FRAC_W-1:0];
    fracB = opBQ[FRAC_W-1:0];
    effA  = (expA == '0) ? EXP_W'(1) : expA;
    effB  = (expB == '0) ? EXP_W'(1) : expB;
    mantA = {(expA != '0), fracA};
    mantB = {(expB != '0), fracB};
    nanA  = (expA == EXP_MAX) && (fracA != '0);
    nanB  = (expB == EXP_MAX) && (fracB != '0);
    infA  = (expA == EXP_MAX) && (fracA == '0);
    infB  = (expB == EXP_MAX) && (fracB == '0);
    aBig  = {effA, mantA} >= {effB, mantB};
  end

  logic             nanQ, infQ, infSgnQ;
  logic [EXP_W-1:0] bigExpQ, smlExpQ;
  logic [MW-1:0]    bigMantQ, smlMantQ;
  logic             bigSgnQ, smlSgnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nanQ <= 1'b0; infQ <= 1'b0; infSgnQ <= 1'b0;
      bigExpQ <= '0; smlExpQ <= '0; bigMantQ <= '0; smlMantQ <= '0;
      bigSgnQ <= 1'b0; smlSgnQ <= 1'b0;
    end else if (strb.unpack) begin
      nanQ    <= nanA || nanB || (infA && infB && (sgnA != sgnB));
      infQ    <= infA || infB;
      infSgnQ <= infA ? sgnA : sgnB;
      if (aBig) begin
        bigExpQ <= effA; bigMantQ <= mantA; bigSgnQ <= sgnA;
        smlExpQ <= effB; smlMantQ <= mantB; smlSgnQ <= sgnB;
      end else begin
        bigExpQ <= effB; bigMantQ <= mantB; bigSgnQ <= sgnB;
        smlExpQ <= effA; smlMantQ <= mantA; smlSgnQ <= sgnA;
      end
    end
  end

  // align: shift the smaller operand right, folding lost bits into sticky
  logic [EXP_W-1:0] expDiff;
  logic [XW-1:0]    smlExt, lostMask, aligned;

  always_comb begin
    expDiff  = bigExpQ - smlExpQ;
    smlExt   = {smlMantQ, 3'b000};
    lostMask = '0;
    if (int'(expDiff) >= XW) begin
      aligned = {{(XW-1){1'b0}}, (smlMantQ != '0)};
    end else begin
      lostMask = (XW'(1) << expDiff) - XW'(1);
      aligned  = (smlExt >> expDiff) | {{(XW-1){1'b0}}, ((smlExt & lostMask) != '0)};
    end
  end

  logic [XW-1:0] alignQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            alignQ <= '0;
    else if (strb.align)  alignQ <= aligned;
  end

  // add or subtract magnitudes
  logic          sameSgn;
  logic [XW:0]   rawSum;

  always_comb begin
    sameSgn = (bigSgnQ == smlSgnQ);
    rawSum  = sameSgn ? ({1'b0, bigMantQ, 3'b000} + {1'b0, alignQ})
                      : ({1'b0, bigMantQ, 3'b000} - {1'b0, alignQ});
  end

  logic [XW:0]     sumQ;
  logic [EI_W-1:0] sumExpQ;
  logic            resSgnQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sumQ <= '0; sumExpQ <= '0; resSgnQ <= 1'b0;
    end else if (strb.addStep) begin
      sumQ    <= rawSum;
      sumExpQ <= {2'b00, bigExpQ};
      resSgnQ <= (rawSum == '0) ? (sameSgn && bigSgnQ) : bigSgnQ;
    end
  end

  // normalise: one right step on carry, else left by leading zeros, floored at exponent 1
  logic [LZ_W-1:0] leadZ;
  logic [EI_W-1:0] shLimit, shAmt;

  always_comb begin
    leadZ = LZ_W'(XW);
    for (int i = 0; i < XW; i++) begin
      if (sumQ[i]) leadZ = LZ_W'(XW - 1 - i);
    end
    shLimit = sumExpQ - EI_W'(1);
    shAmt   = (EI_W'(leadZ) < shLimit) ? EI_W'(leadZ) : shLimit;
  end

  logic [XW-1:0]   normQ;
  logic [EI_W-1:0] normExpQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      normQ <= '0; normExpQ <= '0;
    end else if (strb.norm) begin
      if (sumQ[XW]) begin
        normQ    <= {sumQ[XW:2], (sumQ[1:0] != 2'b00)};
        normExpQ <= sumExpQ + EI_W'(1);
      end else begin
        normQ    <= sumQ[XW-1:0] << shAmt;
        normExpQ <= sumExpQ - shAmt;
      end
    end
  end

  // round to nearest even, then pack with special cases
  logic [MW-1:0]   keepM, finM;
  logic [MW:0]     incM;
  logic            grd, rst, up, ovf;
  logic [EI_W-1:0] finE;
  logic [EXP_W-1:0] expField;
  logic [W-1:0]    resNext;
  logic [2:0]      statNext;

  always_comb begin
    keepM = normQ[XW-1:3];
    grd   = normQ[2];
    rst   = normQ[1] | normQ[0];
    up    = grd && (rst || keepM[0]);
    incM  = {1'b0, keepM} + (MW+1)'(up);
    if (incM[MW]) begin
      finM = incM[MW:1];
      finE = normExpQ + EI_W'(1);
    end else begin
      finM = incM[MW-1:0];
      finE = normExpQ;
    end
    ovf      = finM[MW-1] && (finE >= {2'b00, EXP_MAX});
    expField = finM[MW-1] ? finE[EXP_W-1:0] : '0;
    if (nanQ) begin
      resNext  = NAN_WORD;
      statNext = 3'b100;
    end else if (infQ) begin
      resNext  = {infSgnQ, EXP_MAX, {FRAC_W{1'b0}}};
      statNext = 3'b010;
    end else if (ovf) begin
      resNext  = {resSgnQ, EXP_MAX, {FRAC_W{1'b0}}};
      statNext = 3'b010;
    end else begin
      resNext  = {resSgnQ, expField, finM[FRAC_W-1:0]};
      statNext = {2'b00, (expField == '0) && (finM[FRAC_W-1:0] != '0)};
    end
  end

  logic [W-1:0] resQ, outQ;
  logic [2:0]   statQ, outStatQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ <= '0; statQ <= '0; outQ <= '0; outStatQ <= '0;
    end else begin
      if (strb.round) begin
        resQ  <= resNext;
        statQ <= statNext;
      end
      if (strb.finish) begin
        outQ     <= resQ;
        outStatQ <= statQ;
      end
    end
  end

  assign result    = outQ;
  assign excStatus = outStatQ;

  // R9/R7/R6: at most one exception bit, each consistent with the word
  a_r9_status_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(outStatQ));
  a_r9_nan_word: assert property (@(posedge clk) disable iff (!rstN)
    outStatQ[2] |-> (outQ[W-2:FRAC_W] == EXP_MAX) && outQ[FRAC_W-1]);
  a_r7_inf_word: assert property (@(posedge clk) disable iff (!rstN)
    outStatQ[1] |-> (outQ[W-2:0] == {EXP_MAX, {FRAC_W{1'b0}}}));
  a_r6_sub_word: assert property (@(posedge clk) disable iff (!rstN)
    outStatQ[0] |-> (outQ[W-2:FRAC_W] == '0) && (outQ[FRAC_W-1:0] != '0));

endmodule

// File: rtl/spAddSub.sv
module spAddSub
  import spAddPkg::*;
#(
  parameter int EXP_W   = 8,
  parameter int FRAC_W  = 23,
  parameter int LATENCY = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [EXP_W+FRAC_W:0] opLeft,
  input  logic [EXP_W+FRAC_W:0] opRight,
  input  logic                  doAdd,
  input  logic                  loadStrobe,
  output logic [EXP_W+FRAC_W:0] result,
  output logic [2:0]            excStatus,
  output logic                  busy
);

  stepStrb_t strb;

  spAddCtrl #(.LATENCY(LATENCY)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .loadStrobe (loadStrobe),
    .busy       (busy),
    .strb       (strb)
  );

  spAddPath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .opLeft    (opLeft),
    .opRight   (opRight),
    .doAdd     (doAdd),
    .strb      (strb),
    .result    (result),
    .excStatus (excStatus)
  );

  // R4: no capture while an operation is running
  a_r4_no_capture_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.capture);

  // R3: outputs hold across any idle cycle
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> ($stable(result) && $stable(excStatus)));

endmodule

// File: tb/tb_spAddSub.sv
`timescale 1ns/1ps
module tb_spAddSub;

  localparam real CLK_NS = 8.0;
  localparam int  LAT    = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opLeft = '0, opRight = '0;
  logic        doAdd = 1'b1;
  logic        loadStrobe = 1'b0;
  logic [31:0] result;
  logic [2:0]  excStatus;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  always #(CLK_NS/2) clk = !clk;

  spAddSub dut (
    .clk(clk), .rstN(rstN), .opLeft(opLeft), .opRight(opRight),
    .doAdd(doAdd), .loadStrobe(loadStrobe),
    .result(result), .excStatus(excStatus), .busy(busy)
  );

  // exact reference: operands as wide integers in units of the smallest subnormal
  function automatic logic [34:0] refAdd(logic [31:0] a, logic [31:0] b, logic add);
    logic sa, sb, sr, up;
    logic [7:0] ea, eb;
    logic [22:0] fa, fb;
    logic [279:0] va, vb, mag, rem, half;
    logic [24:0] keep;
    int p, sh, ef;
    sa = a[31]; sb = b[31] ^ !add;
    ea = a[30:23]; eb = b[30:23];
    fa = a[22:0];  fb = b[22:0];
    if ((ea == 8'hFF && fa != 0) || (eb == 8'hFF && fb != 0)) return {3'b100, 32'h7FC00000};
    if (ea == 8'hFF && eb == 8'hFF && sa != sb)               return {3'b100, 32'h7FC00000};
    if (ea == 8'hFF) return {3'b010, sa, 8'hFF, 23'b0};
    if (eb == 8'hFF) return {3'b010, sb, 8'hFF, 23'b0};
    va = 280'({(ea != 0), fa}) << ((ea == 0) ? 0 : int'(ea) - 1);
    vb = 280'({(eb != 0), fb}) << ((eb == 0) ? 0 : int'(eb) - 1);
    if (sa == sb)      begin mag = va + vb; sr = sa; end
    else if (va >= vb) begin mag = va - vb; sr = sa; end
    else               begin mag = vb - va; sr = sb; end
    if (mag == 0) return {3'b000, (sa & sb), 31'b0};
    p = 0;
    for (int i = 0; i < 280; i++) if (mag[i]) p = i;
    if (p <= 23) return {(mag[23] ? 3'b000 : 3'b001), sr, 7'b0, mag[23:0]};
    sh   = p - 23;
    keep = 25'(mag >> sh);
    rem  = mag & ((280'b1 << sh) - 280'b1);
    half = 280'b1 << (sh - 1);
    up   = (rem > half) || (rem == half && keep[0]);
    keep = keep + 25'(up);
    if (keep[24]) begin keep = keep >> 1; sh++; end
    ef = sh + 1;
    if (ef >= 255) return {3'b010, sr, 8'hFF, 23'b0};
    return {3'b000, sr, 8'(ef), keep[22:0]};
  endfunction

  task automatic check(string tag, logic [31:0] gotR, logic [2:0] gotS,
                       logic [31:0] expR, logic [2:0] expS);
    checks++;
    if (gotR !== expR || gotS !== expS) begin
      fails++;
      $display("FAIL %s: got %h/%b expected %h/%b", tag, gotR, gotS, expR, expS);
    end
  endtask

  // one operation; optionally pulse a stray load mid-run (R4)
  task automatic runOp(logic [31:0] a, logic [31:0] b, logic add, string tag, bit stray);
    logic [34:0] exp;
    int hi;
    exp = refAdd(a, b, add);
    @(negedge clk);
    opLeft = a; opRight = b; doAdd = add; loadStrobe = 1'b1;
    @(negedge clk);
    loadStrobe = 1'b0;
    opLeft = $urandom; opRight = $urandom; doAdd = $urandom_range(0, 1) == 1;
    hi = 0;
    while (busy && hi < 100) begin
      hi++;
      if (stray && hi == 5) loadStrobe = 1'b1;
      @(negedge clk);
      loadStrobe = 1'b0;
    end
    checks++;
    if (hi != LAT) begin
      fails++;
      $display("FAIL R3: busy cycles got %0d expected %0d", hi, LAT);
    end
    check(tag, result, excStatus, exp[31:0], exp[34:32]);
  endtask

  function automatic logic [31:0] genOp();
    int r;
    logic s;
    r = $urandom_range(0, 31);
    s = $urandom_range(0, 1) == 1;
    if (r == 0)      return {s, 31'b0};
    else if (r <= 3) return {s, 8'h00, 23'($urandom_range(1, 32'h7FFFFF))};
    else if (r == 4) return {s, 8'hFF, 23'b0};
    else if (r == 5) return {s, 8'hFF, 23'($urandom_range(1, 32'h7FFFFF))};
    else if (r <= 8) return {s, 8'($urandom_range(250, 254)), 23'($urandom)};
    else             return {s, 8'($urandom_range(1, 254)), 23'($urandom)};
  endfunction

  function automatic logic [31:0] nearOp(logic [31:0] a);
    int e;
    e = int'(a[30:23]) + $urandom_range(0, 6) - 3;
    if (e < 0)   e = 0;
    if (e > 254) e = 254;
    return {($urandom_range(0, 1) == 1), 8'(e), 23'($urandom)};
  endfunction

  initial begin
    #(CLK_NS * 190000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] holdR;
    logic [2:0]  holdS;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    // R11: reset values
    check("R11 reset", result, excStatus, 32'h0, 3'b000);
    checks++;
    if (busy !== 1'b0) begin fails++; $display("FAIL R11: busy got %b expected 0", busy); end
    rstN = 1'b1;
    // R2: no strobe, no activity
    opLeft = 32'h3F800000; opRight = 32'h3F800000;
    repeat (4) @(negedge clk);
    checks++;
    if (busy !== 1'b0) begin fails++; $display("FAIL R2: busy got %b expected 0", busy); end
    // R2: capture edge raises busy
    @(negedge clk); loadStrobe = 1'b1;
    @(negedge clk); loadStrobe = 1'b0;
    checks++;
    if (busy !== 1'b1) begin fails++; $display("FAIL R2: busy got %b expected 1", busy); end
    while (busy) @(negedge clk);
    check("R2 1+1", result, excStatus, 32'h40000000, 3'b000);

    // R1 add / subtract select
    runOp(32'h40400000, 32'h3F800000, 1'b0, "R1 3-1", 0);
    runOp(32'h40400000, 32'h3F800000, 1'b1, "R1 3+1", 0);
    runOp(32'h3F800000, 32'h40400000, 1'b0, "R1 1-3", 0);
    // R5 ties
    runOp(32'h3F800000, 32'h33800000, 1'b1, "R5 tie even", 0);
    runOp(32'h3F800001, 32'h33800000, 1'b1, "R5 tie odd", 0);
    runOp(32'h3F800000, 32'h33C00000, 1'b1, "R5 above half", 0);
    runOp(32'h3F800000, 32'h33800000, 1'b0, "R5 cancel", 0);
    // R6 subnormals
    runOp(32'h00000001, 32'h00000001, 1'b1, "R6 tiny sum", 0);
    runOp(32'h00400000, 32'h00400000, 1'b1, "R6 to normal", 0);
    runOp(32'h00800000, 32'h00000001, 1'b0, "R6 to subnormal", 0);
    // R7 overflow
    runOp(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b1, "R7 pos ovf", 0);
    runOp(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b0, "R7 neg ovf", 0);
    // R8 infinity operands
    runOp(32'h7F800000, 32'h3F800000, 1'b1, "R8 inf+1", 0);
    runOp(32'h3F800000, 32'h7F800000, 1'b0, "R8 1-inf", 0);
    // R9 NaN
    runOp(32'h7F800000, 32'h7F800000, 1'b0, "R9 inf-inf", 0);
    runOp(32'h7F800000, 32'hFF800000, 1'b1, "R9 inf+-inf", 0);
    runOp(32'h7FA00000, 32'h3F800000, 1'b1, "R9 nan in", 0);
    // R10 zero signs
    runOp(32'h80000000, 32'h80000000, 1'b1, "R10 -0+-0", 0);
    runOp(32'h80000000, 32'h00000000, 1'b0, "R10 -0-+0", 0);
    runOp(32'h80000000, 32'h00000000, 1'b1, "R10 -0++0", 0);
    runOp(32'h41200000, 32'h41200000, 1'b0, "R10 x-x", 0);
    // R4 stray load while busy
    runOp(32'h40A00000, 32'h40000000, 1'b1, "R4 stray load", 1);
    runOp(32'hC0A00000, 32'h3F000000, 1'b0, "R4 stray load", 1);
    // R3 outputs hold while idle
    holdR = result; holdS = excStatus;
    opLeft = 32'h12345678; opRight = 32'h9ABCDEF0;
    repeat (6) @(negedge clk);
    check("R3 idle hold", result, excStatus, holdR, holdS);

    // R5 random mix
    for (int n = 0; n < 1500; n++) begin
      logic [31:0] a, b;
      a = genOp();
      b = ($urandom_range(0, 1) == 1) ? genOp() : nearOp(a);
      runOp(a, b, $urandom_range(0, 1) == 1, "R5 random", (n % 97) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule